// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This block sits between a processor core and a data memory organised as 32-bit words. For each request it forms the effective byte address as a base value plus a sign-extended 16-bit displacement, wrapping modulo 2^32. From that address it derives the word address, the position of the addressed byte within the word, and whether the access is aligned to its size. For a store it produces a 4-bit byte-enable mask and write data with the value copied into every lane of the access size, so the enables alone pick the lanes that get written.

Lanes are numbered big-endian. Byte offset 0 is the most significant byte of the word. For a load, the unit keeps the offset, size and signedness of the last aligned load it accepted. When the memory returns the word, the unit picks out the byte, halfword or word and extends it to 32 bits, with sign extension or zero extension as the request asked.

A halfword at an odd address, or a word at an address that is not a multiple of 4, is not sent to memory. Instead the unit raises a misalignment flag for one cycle and holds all byte enables low. Both the request path and the load-return path are registered, so each has one cycle of latency.

Top module: `be_lane_unit`

## Requirements
- R1: One cycle after an aligned request (req_vld=1), mem_req is 1 and mem_we equals req_we. mem_waddr holds bits 31:2 of req_base plus req_disp sign-extended to 32 bits, with the sum wrapping modulo 2^32.
- R2: A byte access (req_size=00) at byte offset k (address bits 1:0) sets only bit 3-k of mem_be. Offset 0 gives 1000 and selects data bits 31:24. Offset 3 gives 0001 and selects bits 7:0.
- R3: A halfword access (req_size=01) gives mem_be 1100 at offset 0 and 0011 at offset 2. A word access gives 1111. Size codes 10 and 11 are both word accesses.
- R4: On a store, mem_wdata holds req_wdata[7:0] in all four lanes for a byte, req_wdata[15:0] in both halves for a halfword, and req_wdata unchanged for a word.
- R5: A halfword request at an odd address, or a word request whose address bits 1:0 are not 00, gives, one cycle later, misalign=1, mem_req=0, mem_we=0 and mem_be=0000.
- R6: One cycle after mem_rvld=1, ld_vld is 1. ld_data is taken from mem_rdata using the offset and size of the most recently accepted aligned load. A byte at offset k comes from bits 31-8k down to 24-8k. A halfword at offset 0 comes from bits 31:16, and at offset 2 from bits 15:0. A word is returned unchanged.
- R7: For byte and halfword loads, req_uns=0 sign-extends ld_data to 32 bits and req_uns=1 zero-extends it.
- R8: While rst_n is low, every output is 0.
- R9: One cycle after a cycle with req_vld=0, mem_req, mem_we and misalign are 0 and mem_be is 0000.
- R10: Store requests and misaligned requests do not change the held load offset, size or signedness that a later returned word is extracted with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_uns | input | 1 | Zero-extend load result when 1 |
| req_base | input | 32 | Base address value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data, right-justified |
| mem_rvld | input | 1 | Memory returns a word this cycle |
| mem_rdata | input | 32 | Returned memory word |
| mem_req | output | 1 | Memory access issued |
| mem_we | output | 1 | Issued access is a write |
| mem_waddr | output | 30 | Word address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated write data |
| misalign | output | 1 | Misaligned request rejected |
| ld_vld | output | 1 | Load result valid |
| ld_data | output | 32 | Extracted and extended load data |

## Verification
The assertions assume that req_vld is the only qualifier of a request, and that mem_rvld may arrive in any cycle, including with no load outstanding. The single-byte replication property also assumes that a one-hot enable on a store can only come from a byte access.

The stimulus holds every input at zero during reset and changes inputs only on falling edges. After reset it issues directed stores, loads and misaligned requests, then a long random mix. In the random mix, returned words can be interleaved with stores and rejected requests, which exercises the held load attributes.

// File: rtl/be_lane_pkg.sv
package be_lane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    // The spare size code behaves as a full word.
    function automatic acc_size_e norm_size(input logic [1:0] raw);
        return (raw == 2'd3) ? SZ_WORD : acc_size_e'(raw);
    endfunction

endpackage

// File: rtl/be_lane_addr_gen.sv
module be_lane_addr_gen
    import be_lane_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DISP_W = 16,
    parameter int unsigned LANES  = 4,
    parameter int unsigned OFF_W  = $clog2(LANES)
) (
    input  logic [ADDR_W-1:0]       base_i,
    input  logic [DISP_W-1:0]       disp_i,
    input  acc_size_e               size_i,
    output logic [ADDR_W-OFF_W-1:0] waddr_o,
    output logic [OFF_W-1:0]        off_o,
    output logic                    aligned_o,
    output logic [LANES-1:0]        be_o
);
    localparam int unsigned CNT_W = OFF_W + 1;

    logic [ADDR_W-1:0] eff_addr;
    logic [CNT_W-1:0]  span;
    logic [CNT_W-1:0]  first;
    logic [CNT_W-1:0]  past_end;

    assign eff_addr = base_i + {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    assign waddr_o  = eff_addr[ADDR_W-1:OFF_W];
    assign off_o    = eff_addr[OFF_W-1:0];

    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin
                span      = CNT_W'(1);
                aligned_o = 1'b1;
            end
            SZ_HALF: begin
                span      = CNT_W'(2);
                aligned_o = ~off_o[0];
            end
            default: begin
                span      = CNT_W'(LANES);
                aligned_o = (off_o == '0);
            end
        endcase
    end

    assign first    = {1'b0, off_o};
    assign past_end = first + span;

    // Enable bit i covers big-endian byte position LANES-1-i.
    for (genvar i = 0; i < LANES; i++) begin : g_lane_en
        localparam logic [CNT_W-1:0] POS = CNT_W'(LANES - 1 - i);
        assign be_o[i] = aligned_o && (first <= POS) && (POS < past_end);
    end

endmodule

// File: rtl/be_lane_store_pack.sv
module be_lane_store_pack
    import be_lane_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic [8*LANES-1:0] wdata_i,
    input  acc_size_e          size_i,
    output logic [8*LANES-1:0] lanes_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_pack
        assign lanes_o[8*i +: 8] =
            (size_i == SZ_BYTE) ? wdata_i[7:0] :
            (size_i == SZ_HALF) ? wdata_i[8*(i%2) +: 8] :
                                  wdata_i[8*i +: 8];
    end

endmodule

// File: rtl/be_lane_load_extract.sv
module be_lane_load_extract
    import be_lane_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned OFF_W = $clog2(LANES)
) (
    input  logic [8*LANES-1:0] word_i,
    input  logic [OFF_W-1:0]   off_i,
    input  acc_size_e          size_i,
    input  logic               uns_i,
    output logic [8*LANES-1:0] data_o
);
    localparam int unsigned DATA_W = 8 * LANES;

    logic [OFF_W-1:0] off_half;
    logic [7:0]       byte_sel;
    logic [15:0]      half_sel;
    logic             fill;

    assign off_half = {off_i[OFF_W-1:1], 1'b0};
    assign byte_sel = word_i[8*(LANES-1-int'(off_i)) +: 8];
    assign half_sel = word_i[8*(LANES-2-int'(off_half)) +: 16];

    always_comb begin
        fill = 1'b0;
        unique case (size_i)
            SZ_BYTE: begin
                fill   = ~uns_i & byte_sel[7];
                data_o = {{(DATA_W-8){fill}}, byte_sel};
            end
            SZ_HALF: begin
                fill   = ~uns_i & half_sel[15];
                data_o = {{(DATA_W-16){fill}}, half_sel};
            end
            default: data_o = word_i;
        endcase
    end

endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
    import be_lane_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DISP_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_vld,
    input  logic                          req_we,
    input  logic [1:0]                    req_size,
    input  logic                          req_uns,
    input  logic [ADDR_W-1:0]             req_base,
    input  logic [DISP_W-1:0]             req_disp,
    input  logic [DATA_W-1:0]             req_wdata,
    input  logic                          mem_rvld,
    input  logic [DATA_W-1:0]             mem_rdata,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_waddr,
    output logic [DATA_W/8-1:0]           mem_be,
    output logic [DATA_W-1:0]             mem_wdata,
    output logic                          misalign,
    output logic                          ld_vld,
    output logic [DATA_W-1:0]             ld_data
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(LANES);
    localparam int unsigned WA_W  = ADDR_W - OFF_W;

    typedef struct packed {
        logic              req;
        logic              we;
        logic              mis;
        logic [WA_W-1:0]   waddr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        logic [OFF_W-1:0]  ld_off;
        acc_size_e         ld_size;
        logic              ld_uns;
        logic              ld_vld;
        logic [DATA_W-1:0] ld_data;
    } state_t;

    state_t st_d, st_q;

    acc_size_e         size_n;
    logic [WA_W-1:0]   waddr_c;
    logic [OFF_W-1:0]  off_c;
    logic              aligned_c;
    logic [LANES-1:0]  be_c;
    logic [DATA_W-1:0] pack_c;
    logic [DATA_W-1:0] ext_c;

    assign size_n = norm_size(req_size);

    be_lane_addr_gen #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .LANES  (LANES),
        .OFF_W  (OFF_W)
    ) i_addr (
        .base_i    (req_base),
        .disp_i    (req_disp),
        .size_i    (size_n),
        .waddr_o   (waddr_c),
        .off_o     (off_c),
        .aligned_o (aligned_c),
        .be_o      (be_c)
    );

    be_lane_store_pack #(
        .LANES (LANES)
    ) i_pack (
        .wdata_i (req_wdata),
        .size_i  (size_n),
        .lanes_o (pack_c)
    );

    be_lane_load_extract #(
        .LANES (LANES),
        .OFF_W (OFF_W)
    ) i_ext (
        .word_i (mem_rdata),
        .off_i  (st_q.ld_off),
        .size_i (st_q.ld_size),
        .uns_i  (st_q.ld_uns),
        .data_o (ext_c)
    );

    always_comb begin
        st_d        = st_q;
        st_d.req    = req_vld & aligned_c;
        st_d.we     = req_vld & aligned_c & req_we;
        st_d.mis    = req_vld & ~aligned_c;
        st_d.be     = req_vld ? be_c : '0;
        if (req_vld) begin
            st_d.waddr = waddr_c;
        end
        if (req_vld && aligned_c && req_we) begin
            st_d.wdata = pack_c;
        end
        if (req_vld && aligned_c && !req_we) begin
            st_d.ld_off  = off_c;
            st_d.ld_size = size_n;
            st_d.ld_uns  = req_uns;
        end
        st_d.ld_vld = mem_rvld;
        if (mem_rvld) begin
            st_d.ld_data = ext_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req   = st_q.req;
    assign mem_we    = st_q.we;
    assign mem_waddr = st_q.waddr;
    assign mem_be    = st_q.be;
    assign mem_wdata = st_q.wdata;
    assign misalign  = st_q.mis;
    assign ld_vld    = st_q.ld_vld;
    assign ld_data   = st_q.ld_data;

endmodule

// File: rtl/be_lane_unit_chk.sv
module be_lane_unit_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_vld,
    input logic                mem_rvld,
    input logic                mem_req,
    input logic                mem_we,
    input logic [DATA_W/8-1:0] mem_be,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic                misalign,
    input logic                ld_vld
);
    localparam int unsigned LANES = DATA_W / 8;

    AST_REQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(req_vld)); // R1

    AST_BE_POPULATION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                     || $countones(mem_be) == LANES)); // R3

    AST_BYTE_STORE_REPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $countones(mem_be) == 1)
            |-> (mem_wdata == {LANES{mem_wdata[7:0]}})); // R4

    AST_MISALIGN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_req && !mem_we && mem_be == '0)); // R5

    AST_LOAD_RETURN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_rvld) |-> ld_vld); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_vld) |-> (!mem_req && !misalign && mem_be == '0)); // R9

endmodule

bind be_lane_unit be_lane_unit_chk #(
    .DATA_W (DATA_W)
) i_be_lane_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .mem_rvld  (mem_rvld),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .misalign  (misalign),
    .ld_vld    (ld_vld)
);

// File: tb/test_be_lane_unit.sv
`timescale 1ns/1ps
module test_be_lane_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0, req_we = 1'b0, req_uns = 1'b0, mem_rvld = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_base = '0, req_wdata = '0, mem_rdata = '0;
    logic [15:0] req_disp = '0;
    logic        mem_req, mem_we, misalign, ld_vld;
    logic [29:0] mem_waddr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, ld_data;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit done = 0, live = 0;

    always #5 clk = ~clk;

    be_lane_unit i_be_lane_unit (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_we(req_we),
        .req_size(req_size), .req_uns(req_uns), .req_base(req_base),
        .req_disp(req_disp), .req_wdata(req_wdata), .mem_rvld(mem_rvld),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .misalign(misalign), .ld_vld(ld_vld), .ld_data(ld_data)
    );

    // Reference model state.
    logic        e_req, e_we, e_mis, e_ldv;
    logic [29:0] e_waddr;
    logic [3:0]  e_be;
    logic [31:0] e_wdata, e_ldd;
    string       t_be, t_ld;
    int          h_off = 0, h_sz = 0;
    bit          h_uns = 0, h_stale = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            live = 0;
            h_off = 0; h_sz = 0; h_uns = 0; h_stale = 0;
        end else begin
            int sz, off, n;
            bit al;
            logic [31:0] ea, w;
            logic [31:0] v;
            ea  = req_base + {{16{req_disp[15]}}, req_disp};
            off = int'(ea[1:0]);
            sz  = (req_size == 2'd3) ? 2 : int'(req_size);
            n   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
            al  = (sz == 0) || (off % n == 0);
            e_req = req_vld && al;
            e_we  = req_vld && al && req_we;
            e_mis = req_vld && !al;
            e_be  = '0;
            if (e_req)
                for (int k = 0; k < 4; k++)
                    if (k >= off && k < off + n) e_be[3-k] = 1'b1;
            t_be = !req_vld ? "R9" : !al ? "R5" : (sz == 0) ? "R2" : "R3";
            if (req_vld) e_waddr = ea[31:2];
            w = req_wdata;
            if (e_we) e_wdata = (sz == 0) ? {4{w[7:0]}} : (sz == 1) ? {2{w[15:0]}} : w;
            // load return uses the held attributes from before this edge
            e_ldv = mem_rvld;
            if (mem_rvld) begin
                if (h_sz == 0) begin
                    v = (mem_rdata >> (8 * (3 - h_off))) & 32'hff;
                    if (!h_uns && v[7]) v = v | 32'hffffff00;
                end else if (h_sz == 1) begin
                    v = (mem_rdata >> (8 * (2 - h_off))) & 32'hffff;
                    if (!h_uns && v[15]) v = v | 32'hffff0000;
                end else v = mem_rdata;
                e_ldd = v;
                t_ld = $sformatf("%s%s", (h_sz == 2) ? "R6" : (h_uns ? "R6 R7 zext" : "R6 R7 sext"),
                                 h_stale ? " R10" : "");
            end
            if (req_vld && al && !req_we) begin
                h_off = off; h_sz = sz; h_uns = req_uns; h_stale = 0;
            end else if (req_vld) h_stale = 1;
            live = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && live) begin
            chk("R1", "mem_req", {31'b0, mem_req}, {31'b0, e_req});
            chk("R5", "misalign", {31'b0, misalign}, {31'b0, e_mis});
            chk("R1", "mem_we", {31'b0, mem_we}, {31'b0, e_we});
            chk(t_be, "mem_be", {28'b0, mem_be}, {28'b0, e_be});
            if (e_req) chk("R1", "mem_waddr", {2'b0, mem_waddr}, {2'b0, e_waddr});
            if (e_we)  chk("R4", "mem_wdata", mem_wdata, e_wdata);
            chk("R6", "ld_vld", {31'b0, ld_vld}, {31'b0, e_ldv});
            if (e_ldv) chk(t_ld, "ld_data", ld_data, e_ldd);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic op(input logic v, input logic we, input logic [1:0] sz, input logic u,
                      input logic [31:0] b, input logic [15:0] d, input logic [31:0] wd,
                      input logic rv, input logic [31:0] rd);
        req_vld = v; req_we = we; req_size = sz; req_uns = u;
        req_base = b; req_disp = d; req_wdata = wd; mem_rvld = rv; mem_rdata = rd;
        @(negedge clk);
    endtask

    task automatic idle();
        op(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: outputs while reset is held
        chk("R8", "mem_req", {31'b0, mem_req}, 0);
        chk("R8", "mem_be", {28'b0, mem_be}, 0);
        chk("R8", "mem_wdata", mem_wdata, 0);
        chk("R8", "misalign", {31'b0, misalign}, 0);
        chk("R8", "ld_vld/ld_data", ld_data | {31'b0, ld_vld}, 0);
        chk("R8", "mem_waddr", {2'b0, mem_waddr}, 0);
        rst_n = 1'b1;
        idle();
        // R2 byte stores at each offset, R3 halfword/word, R4 replication
        for (int k = 0; k < 4; k++) op(1, 1, 0, 0, 32'h100 + k, 0, 32'hA1B2C3D4, 0, 0);
        op(1, 1, 1, 0, 32'h200, 0, 32'h1234BEEF, 0, 0);
        op(1, 1, 1, 0, 32'h202, 0, 32'h1234BEEF, 0, 0);
        op(1, 1, 2, 0, 32'h300, 0, 32'hCAFEF00D, 0, 0);
        op(1, 1, 3, 0, 32'h304, 0, 32'h01020304, 0, 0);
        // R1 negative displacement and wrap-around
        op(1, 1, 2, 0, 32'h208, 16'hFFFC, 32'h55, 0, 0);
        op(1, 0, 2, 0, 32'hFFFF_FFFF, 16'h0001, 0, 0, 0);
        idle();
        // R5 misaligned halfword and word
        op(1, 1, 1, 0, 32'h401, 0, 32'hFFFF, 0, 0);
        op(1, 0, 1, 0, 32'h403, 0, 0, 0, 0);
        for (int k = 1; k < 4; k++) op(1, 0, 2, 0, 32'h500 + k, 0, 0, 0, 0);
        op(1, 1, 3, 0, 32'h502, 0, 0, 0, 0);
        idle();
        // R6 R7 loads of each shape, signed and unsigned
        for (int u = 0; u < 2; u++) begin
            for (int k = 0; k < 4; k++) begin
                op(1, 0, 0, 1'(u), 32'h600 + k, 0, 0, 0, 0);
                op(0, 0, 0, 0, 0, 0, 0, 1, 32'h80F17F9C);
            end
            for (int k = 0; k < 4; k += 2) begin
                op(1, 0, 1, 1'(u), 32'h700 + k, 0, 0, 0, 0);
                op(0, 0, 0, 0, 0, 0, 0, 1, 32'h8001_7FFE);
                op(0, 0, 0, 0, 0, 0, 0, 1, 32'h7001_F00E);
            end
        end
        op(1, 0, 2, 1, 32'h800, 0, 0, 0, 0);
        op(0, 0, 0, 0, 0, 0, 0, 1, 32'hDEADBEEF);
        // R10 store and misaligned request between load and its data
        op(1, 0, 0, 0, 32'h901, 0, 0, 0, 0);
        op(1, 1, 2, 1, 32'h904, 0, 32'h11223344, 0, 0);
        op(1, 0, 2, 1, 32'h906, 0, 0, 0, 0);
        op(0, 0, 0, 0, 0, 0, 0, 1, 32'h12_F3_56_78);
        idle();
        // mixed random traffic
        for (int i = 0; i < 3000; i++)
            op(($urandom % 4) != 0, $urandom % 2, 2'($urandom), $urandom % 2,
               $urandom, 16'($urandom), $urandom, ($urandom % 3) == 0, $urandom);
        idle(); idle();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule